// File: doc/BRIEF.md
# Secure Mode and Region Access Guard

This block follows the security state of one running process and rules on every memory access it makes. Four event pulses drive the mode: enter, suspend, resume and exit. The modes are standard (insecure), measuring, secure, and suspended-secure.

Leaving standard mode starts a measurement handshake. The block raises `hash_start` and holds in the measuring state until `hash_done` arrives. Only then does secure mode take effect. While measuring, the access port stalls.

Each access is matched against a set of programmable address windows. Every window carries a protection class. The verdict depends on three things:

- the current mode,
- the class of the matched window,
- whether the access writes.

Alongside the verdict, the block tells the memory path whether the access needs an integrity check and whether it needs decryption.

The access port follows valid/ready rules. `acc_ready` is low only in the measuring state. An access counts as presented only in a cycle where both `acc_valid` and `acc_ready` are high. The verdict for that access (`acc_permit` or `acc_fault`, plus `acc_verify` and `acc_decrypt`) is combinational and valid in that same cycle. A requester that sees `acc_ready` low must hold its access until ready returns. The verdict pins stay low in every cycle without a handshake.

Top module: `sec_region_guard`

## Requirements
- R1: After reset, `mode` is 0 (standard), `hash_start` is low and `acc_ready` is high.
- R2: An enter event in standard mode moves `mode` to 1 (measuring). In that state `hash_start` is high and `acc_ready` is low. The state holds until `hash_done` is sampled high; `mode` becomes 2 (secure) on the following clock edge.
- R3: In secure mode, a suspend event moves `mode` to 3 (suspended) and an exit event moves it to 0. When both arrive in the same cycle, exit wins.
- R4: In suspended mode, a resume event with `pc` equal to `cfg_resume_pc` returns `mode` to 2. A resume at any other `pc` leaves `mode` at 3 and raises `resume_fault` in that cycle.
- R5: Window i matches when `cfg_en[i]` is set and `cfg_base[i] <= acc_addr <= cfg_limit[i]`. Among matching windows the lowest index wins. With no match the access is unprotected. The 3-bit class codes are:
  - 0: unprotected
  - 1: static verified
  - 2: static encrypted
  - 3: dynamic verified
  - 4: dynamic encrypted
  - 5 to 7: treated as unprotected
- R6: A write to class 1 or 2 faults in every mode.
- R7: In standard and suspended modes, any access to classes 1 to 4 faults. Unprotected accesses are permitted in every mode.
- R8: A permitted access to classes 1 to 4 raises `acc_verify`. A permitted access to class 2 or 4 also raises `acc_decrypt`. Both flags are low on a fault and on unprotected accesses.
- R9: Events with no meaning in the current mode are ignored: they change neither `mode` nor `resume_fault`. Examples are enter outside standard mode, suspend or resume in standard mode, and exit in suspended mode.
- R10: An access with `acc_fetch` high is judged as a read, whatever the value of `acc_write`.
- R11: When `acc_valid` and `acc_ready` are both high, exactly one of `acc_permit` and `acc_fault` is high. Otherwise all four verdict outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_enter | input | 1 | Enter-secure event pulse |
| evt_suspend | input | 1 | Suspend event pulse |
| evt_resume | input | 1 | Resume event pulse |
| evt_exit | input | 1 | Exit-secure event pulse |
| pc | input | AW | Program counter of the current event |
| cfg_resume_pc | input | AW | Only address at which resume is accepted |
| hash_start | output | 1 | High while measurement is requested |
| hash_done | input | 1 | Measurement finished |
| cfg_en | input | NREG | Per-window enable |
| cfg_base | input | NREG*AW | Window lower bounds, window i at bits [i*AW +: AW] |
| cfg_limit | input | NREG*AW | Window upper bounds (inclusive) |
| cfg_class | input | NREG*3 | Window class codes, window i at bits [i*3 +: 3] |
| acc_valid | input | 1 | Access presented |
| acc_ready | output | 1 | Access accepted this cycle |
| acc_addr | input | AW | Access address |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_permit | output | 1 | Access allowed |
| acc_fault | output | 1 | Access refused |
| acc_verify | output | 1 | Memory path must integrity-check |
| acc_decrypt | output | 1 | Memory path must decrypt |
| mode | output | 2 | 0 standard, 1 measuring, 2 secure, 3 suspended |
| resume_fault | output | 1 | Resume refused at a wrong address |

## Verification
A wrong mode register shows up on `mode` in the cycle after the bad transition. It also shows up at once in the verdict of the next protected access, because the same class can flip from permit to fault.

A window-priority or class-decode error shows up in the same cycle as the access. It appears as wrong `acc_verify` or `acc_decrypt` flags, or as a fault on a write that should have been allowed.

The bench compares every output against a behavioural model on every clock. Any divergence is therefore caught in the cycle it first appears.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    M_STD  = 2'd0,
    M_MEAS = 2'd1,
    M_SEC  = 2'd2,
    M_SUSP = 2'd3
  } mode_e;

  localparam int CLS_W = 3;

  // 1..4 are the protected classes; everything else is open memory.
  function automatic logic cls_prot(input logic [CLS_W-1:0] c);
    return (c >= 3'd1) && (c <= 3'd4);
  endfunction

  function automatic logic cls_static(input logic [CLS_W-1:0] c);
    return (c == 3'd1) || (c == 3'd2);
  endfunction

  function automatic logic cls_enc(input logic [CLS_W-1:0] c);
    return (c == 3'd2) || (c == 3'd4);
  endfunction
endpackage

// File: rtl/sg_mode_fsm.sv
module sg_mode_fsm
  import sg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  evt_enter,
  input  logic  evt_suspend,
  input  logic  evt_resume,
  input  logic  evt_exit,
  input  logic  pc_at_entry,
  input  logic  hash_done,
  output mode_e mode_q,
  output logic  resume_fault
);
  mode_e mode_nx;

  always_comb begin
    mode_nx = mode_q;
    unique case (mode_q)
      M_STD:  if (evt_enter) mode_nx = M_MEAS;
      M_MEAS: if (hash_done) mode_nx = M_SEC;
      M_SEC: begin
        if (evt_exit)         mode_nx = M_STD;
        else if (evt_suspend) mode_nx = M_SUSP;
      end
      M_SUSP: if (evt_resume && pc_at_entry) mode_nx = M_SEC;
      default: mode_nx = M_STD;
    endcase
  end

  assign resume_fault = (mode_q == M_SUSP) && evt_resume && !pc_at_entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_STD;
    else        mode_q <= mode_nx;
  end
endmodule

// File: rtl/sg_region_match.sv
module sg_region_match
  import sg_pkg::*;
#(
  parameter int NREG = 4,
  parameter int AW   = 32
) (
  input  logic [AW-1:0]         addr,
  input  logic [NREG-1:0]       cfg_en,
  input  logic [NREG*AW-1:0]    cfg_base,
  input  logic [NREG*AW-1:0]    cfg_limit,
  input  logic [NREG*CLS_W-1:0] cfg_class,
  output logic [CLS_W-1:0]      cls
);
  logic [NREG-1:0] hit;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_cmp
    assign hit[gi] = cfg_en[gi]
                   && (addr >= cfg_base[gi*AW +: AW])
                   && (addr <= cfg_limit[gi*AW +: AW]);
  end

  // Scan from the top index down so the lowest matching window lands last.
  always_comb begin
    cls = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) cls = cfg_class[i*CLS_W +: CLS_W];
    end
  end
endmodule

// File: rtl/sg_access_rule.sv
module sg_access_rule
  import sg_pkg::*;
(
  input  mode_e            mode_q,
  input  logic [CLS_W-1:0] cls,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_fetch,
  output logic             acc_ready,
  output logic             acc_permit,
  output logic             acc_fault,
  output logic             acc_verify,
  output logic             acc_decrypt
);
  logic take, wr_eff, deny;

  assign acc_ready = (mode_q != M_MEAS);
  assign take      = acc_valid && acc_ready;
  assign wr_eff    = acc_write && !acc_fetch;
  assign deny      = (cls_static(cls) && wr_eff)
                   || (cls_prot(cls) && (mode_q != M_SEC));

  assign acc_fault   = take && deny;
  assign acc_permit  = take && !deny;
  assign acc_verify  = acc_permit && cls_prot(cls);
  assign acc_decrypt = acc_permit && cls_enc(cls);
endmodule

// File: rtl/sec_region_guard.sv
module sec_region_guard
  import sg_pkg::*;
#(
  parameter int NREG = 4,
  parameter int AW   = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  evt_enter,
  input  logic                  evt_suspend,
  input  logic                  evt_resume,
  input  logic                  evt_exit,
  input  logic [AW-1:0]         pc,
  input  logic [AW-1:0]         cfg_resume_pc,
  output logic                  hash_start,
  input  logic                  hash_done,
  input  logic [NREG-1:0]       cfg_en,
  input  logic [NREG*AW-1:0]    cfg_base,
  input  logic [NREG*AW-1:0]    cfg_limit,
  input  logic [NREG*CLS_W-1:0] cfg_class,
  input  logic                  acc_valid,
  output logic                  acc_ready,
  input  logic [AW-1:0]         acc_addr,
  input  logic                  acc_write,
  input  logic                  acc_fetch,
  output logic                  acc_permit,
  output logic                  acc_fault,
  output logic                  acc_verify,
  output logic                  acc_decrypt,
  output logic [1:0]            mode,
  output logic                  resume_fault
);
  mode_e            mode_q;
  logic [CLS_W-1:0] cls;

  sg_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_enter    (evt_enter),
    .evt_suspend  (evt_suspend),
    .evt_resume   (evt_resume),
    .evt_exit     (evt_exit),
    .pc_at_entry  (pc == cfg_resume_pc),
    .hash_done    (hash_done),
    .mode_q       (mode_q),
    .resume_fault (resume_fault)
  );

  sg_region_match #(.NREG(NREG), .AW(AW)) u_match (
    .addr      (acc_addr),
    .cfg_en    (cfg_en),
    .cfg_base  (cfg_base),
    .cfg_limit (cfg_limit),
    .cfg_class (cfg_class),
    .cls       (cls)
  );

  sg_access_rule u_rule (
    .mode_q      (mode_q),
    .cls         (cls),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_fetch   (acc_fetch),
    .acc_ready   (acc_ready),
    .acc_permit  (acc_permit),
    .acc_fault   (acc_fault),
    .acc_verify  (acc_verify),
    .acc_decrypt (acc_decrypt)
  );

  assign mode       = mode_q;
  assign hash_start = (mode_q == M_MEAS);
endmodule

// File: rtl/sg_guard_chk.sv
module sg_guard_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          evt_resume,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] cfg_resume_pc,
  input logic          hash_start,
  input logic          hash_done,
  input logic          acc_valid,
  input logic          acc_ready,
  input logic          acc_permit,
  input logic          acc_fault,
  input logic          acc_verify,
  input logic          acc_decrypt,
  input logic [1:0]    mode,
  input logic          resume_fault
);
  p_one_verdict_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |-> ($countones({acc_permit, acc_fault}) == 1));

  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_ready) |-> !(acc_permit || acc_fault || acc_verify || acc_decrypt));

  p_meas_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (!acc_ready && hash_start));

  p_meas_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !hash_done) |=> (mode == 2'd1));

  p_resume_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !(evt_resume && pc == cfg_resume_pc)) |=> (mode == 2'd3));

  p_resume_fault_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resume_fault |-> (mode == 2'd3));

  p_prot_secure_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_verify |-> (mode == 2'd2));

  p_decrypt_verify_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_decrypt |-> acc_verify);
endmodule

bind sec_region_guard sg_guard_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .evt_resume    (evt_resume),
  .pc            (pc),
  .cfg_resume_pc (cfg_resume_pc),
  .hash_start    (hash_start),
  .hash_done     (hash_done),
  .acc_valid     (acc_valid),
  .acc_ready     (acc_ready),
  .acc_permit    (acc_permit),
  .acc_fault     (acc_fault),
  .acc_verify    (acc_verify),
  .acc_decrypt   (acc_decrypt),
  .mode          (mode),
  .resume_fault  (resume_fault)
);

// File: tb/sec_region_guard_tb.sv
module sec_region_guard_tb;
  localparam int NREG = 4;
  localparam int AW   = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic evt_enter = 0, evt_suspend = 0, evt_resume = 0, evt_exit = 0;
  logic [AW-1:0] pc = '0;
  logic [AW-1:0] cfg_resume_pc = 32'h400;
  logic hash_start, hash_done = 0;
  logic [NREG-1:0] cfg_en = '1;
  logic [NREG*AW-1:0] cfg_base, cfg_limit;
  logic [NREG*3-1:0] cfg_class;
  logic acc_valid = 0, acc_ready, acc_write = 0, acc_fetch = 0;
  logic [AW-1:0] acc_addr = '0;
  logic acc_permit, acc_fault, acc_verify, acc_decrypt, resume_fault;
  logic [1:0] mode;

  int checks = 0, errors = 0;
  int m_mode = 0;
  bit finished = 0;
  int rb[NREG] = '{32'h1000, 32'h1800, 32'h3000, 32'h4000};
  int rl[NREG] = '{32'h1FFF, 32'h2FFF, 32'h3FFF, 32'h4FFF};
  int rc[NREG] = '{1, 4, 2, 3};

  always #10 clk = ~clk;

  sec_region_guard #(.NREG(NREG), .AW(AW)) u_dut (.*);

  initial begin
    for (int i = 0; i < NREG; i++) begin
      cfg_base[i*AW +: AW]  = rb[i];
      cfg_limit[i*AW +: AW] = rl[i];
      cfg_class[i*3 +: 3]   = rc[i][2:0];
    end
  end

  function automatic int model_class(int a);
    for (int i = 0; i < NREG; i++)
      if (cfg_en[i] && a >= rb[i] && a <= rl[i]) return (rc[i] <= 4) ? rc[i] : 0;
    return 0;
  endfunction

  // Compare all outputs against the model, then advance the model one edge.
  task automatic cyc(input string tag);
    logic [8:0] exp_v, act_v;
    int c, nm;
    bit rdy, take, wr, prot, deny, perm, rf;
    #1;
    rdy  = !rst_n ? 1 : (m_mode != 1);
    c    = model_class(int'(acc_addr));
    take = rst_n && acc_valid && rdy;
    wr   = acc_write && !acc_fetch;
    prot = (c >= 1 && c <= 4);
    deny = ((c == 1 || c == 2) && wr) || (prot && m_mode != 2);
    perm = take && !deny;
    rf   = rst_n && m_mode == 3 && evt_resume && pc != cfg_resume_pc;
    exp_v = {2'(m_mode), (m_mode == 1), rdy, perm, take && deny,
             perm && prot, perm && (c == 2 || c == 4), rf};
    act_v = {mode, hash_start, acc_ready, acc_permit, acc_fault,
             acc_verify, acc_decrypt, resume_fault};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: {mode,hs,rdy,perm,flt,ver,dec,rf} actual %b expected %b",
               tag, act_v, exp_v);
    end
    nm = m_mode;
    if (!rst_n) nm = 0;
    else case (m_mode)
      0: if (evt_enter) nm = 1;
      1: if (hash_done) nm = 2;
      2: if (evt_exit) nm = 0; else if (evt_suspend) nm = 3;
      3: if (evt_resume && pc == cfg_resume_pc) nm = 2;
      default: nm = 0;
    endcase
    @(posedge clk);
    m_mode = nm;
    @(negedge clk);
  endtask

  task automatic acc(input int a, input bit w, input bit f, input string tag);
    acc_valid = 1; acc_addr = a; acc_write = w; acc_fetch = f;
    cyc(tag);
    acc_valid = 0; acc_write = 0; acc_fetch = 0;
  endtask

  task automatic ev(input bit en, input bit su, input bit re, input bit ex,
                    input int p, input string tag);
    evt_enter = en; evt_suspend = su; evt_resume = re; evt_exit = ex; pc = p;
    cyc(tag);
    {evt_enter, evt_suspend, evt_resume, evt_exit} = '0;
  endtask

  initial begin
    @(negedge clk);
    cyc("R1 in reset");
    rst_n = 1;
    cyc("R1 after reset");
    // standard mode
    acc(32'h8000, 1, 0, "R7 open write in standard");
    acc(32'h1100, 0, 0, "R7 protected read in standard");
    acc(32'h2000, 1, 0, "R7 encrypted write in standard");
    acc(32'h1100, 1, 0, "R6 static write in standard");
    ev(0, 1, 0, 0, 0, "R9 suspend in standard");
    ev(0, 0, 1, 0, 32'h999, "R9 resume in standard");
    acc_valid = 0; cyc("R11 idle port");
    // measurement
    ev(1, 0, 0, 0, 0, "R2 enter");
    acc_valid = 1; acc_addr = 32'h8000;
    for (int k = 0; k < 3; k++) cyc("R2 stalled while measuring");
    ev(0, 1, 0, 1, 0, "R9 events ignored while measuring");
    hash_done = 1; cyc("R2 hash done"); hash_done = 0;
    acc_valid = 0;
    // secure mode
    acc(32'h1100, 0, 0, "R8 static verified read");
    acc(32'h1900, 1, 0, "R5 overlap picks window 0 so R6 static write");
    acc(32'h2000, 1, 0, "R8 dynamic encrypted write");
    acc(32'h3100, 0, 0, "R8 static encrypted read");
    acc(32'h3100, 1, 0, "R6 static encrypted write");
    acc(32'h4100, 1, 0, "R8 dynamic verified write");
    acc(32'h8000, 0, 0, "R8 open access no flags");
    acc(32'h1100, 1, 1, "R10 fetch with write bit");
    acc(32'h3000, 0, 0, "R5 lower bound inclusive");
    acc(32'h4FFF, 0, 0, "R5 upper bound inclusive");
    cfg_en[0] = 0;
    acc(32'h1900, 1, 0, "R5 window 0 disabled");
    cfg_en[0] = 1;
    ev(1, 0, 0, 0, 0, "R9 enter in secure");
    ev(0, 0, 1, 0, 32'h123, "R9 resume in secure");
    // suspended
    ev(0, 1, 0, 0, 0, "R3 suspend");
    acc(32'h4100, 0, 0, "R7 protected read in suspended");
    acc(32'h8000, 1, 0, "R7 open write in suspended");
    ev(0, 0, 0, 1, 0, "R9 exit in suspended");
    ev(0, 0, 1, 0, 32'h404, "R4 resume wrong address");
    acc(32'h2000, 0, 0, "R4 still suspended");
    ev(0, 0, 1, 0, 32'h400, "R4 resume at entry");
    acc(32'h2000, 0, 0, "R4 back in secure");
    ev(0, 1, 0, 1, 0, "R3 exit beats suspend");
    acc(32'h4100, 1, 0, "R3 standard after exit");
    // second pass through measurement then exit
    ev(1, 0, 0, 0, 0, "R2 re-enter");
    hash_done = 1; cyc("R2 immediate done"); hash_done = 0;
    ev(0, 0, 0, 1, 0, "R3 exit from secure");
    cyc("R3 standard");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule